// File: doc/BRIEF.md
# Two-Speed Start-Up Clock Switcher

This block chooses the clock that drives a small microcontroller core. A crystal oscillator needs time to settle after power-on or after sleep, so the block lets the core run from the on-chip oscillator while a start-up counter, clocked by the crystal, counts its first 1024 rising edges. When the count completes, the block moves the system clock over to the crystal through a break-before-make handover, so the output never carries a short pulse.

The source is chosen when the sequence starts. A software select bit forces the internal oscillator. Otherwise the configured external mode decides. The three crystal modes (code 0 low-power, code 1 standard, code 2 high-speed) go through the timed start-up. Codes 3 to 7 are sources that need no settling, and the block switches to them at once. A switchover enable chooses between running the core during the count and holding the clock low for the count. A sleep request stops the output and abandons any count in progress. A wake event starts the sequence again from the beginning. The status output reports which source is really active.

Top module: `tss_clock_switcher`

## Requirements
- R1: From reset until the first reset-release pulse, `sys_clk` stays low and `ext_active` is 0.
- R2: With `clk_sel`=0, a crystal mode (code 0, 1 or 2) and `sw_en`=1, `sys_clk` follows `int_clk` after the start pulse and while the count runs, and `ext_active` stays 0.
- R3: In a crystal mode, `ext_active` rises only after at least 1024 rising edges of `ext_clk` since the start pulse, and no more than 6 edges later than that.
- R4: `ext_active` rises on a falling edge of `int_clk`. `sys_clk` then stays low until the next falling edge of `ext_clk`, and after that it follows `ext_clk`.
- R5: `sys_clk` never has a high or low phase shorter than the shorter half-period of the two oscillators.
- R6: With `clk_sel`=1, `sys_clk` follows `int_clk` and `ext_active` stays 0, whatever the mode.
- R7: With `clk_sel`=0 and a non-crystal mode (codes 3 to 7), `sys_clk` follows `ext_clk` without a count, and `ext_active` rises within 6 external edges of the start pulse.
- R8: A one-cycle `sleep_req` gates `sys_clk` low and clears `ext_active`. A sleep request during a count abandons it, and `ext_active` stays 0.
- R9: A `wake` pulse after sleep starts the whole sequence again, including a fresh 1024-edge count in a crystal mode.
- R10: With `sw_en`=0 in a crystal mode, `sys_clk` is held low during the count and then follows `ext_clk`. `ext_active` rises as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| int_clk | input | 1 | Internal oscillator clock, also the control clock |
| ext_clk | input | 1 | External oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_release | input | 1 | One-cycle pulse (int_clk domain) when reset and power-up delay are over |
| wake | input | 1 | One-cycle pulse (int_clk domain) that ends sleep |
| sleep_req | input | 1 | One-cycle pulse (int_clk domain) that enters sleep |
| clk_sel | input | 1 | Software select: 1 forces the internal oscillator |
| osc_mode | input | 3 | External mode: 0,1,2 crystal; 3..7 no settling needed |
| sw_en | input | 1 | Internal/external switchover enable |
| sys_clk | output | 1 | System clock |
| ext_active | output | 1 | 1 while the external clock drives sys_clk |

## Verification
The hardest case to reach is a sleep request that lands in the middle of a count. The counter is then cleared, and no stale done indication may leak into the next sequence. The stimulus wakes in low-power crystal mode, waits about 300 external edges, and sends sleep. It then waits well past 1024 edges and checks that the flag never moved and the clock stayed low. The two oscillators run at periods whose edges never coincide. That makes every handover happen at a different phase offset, and a pulse-width monitor watches every level change of the output.

// File: rtl/tss_pkg.sv
package tss_pkg;

   typedef enum logic [2:0] {
      ST_HOLD  = 3'd0,
      ST_COUNT = 3'd1,
      ST_INT   = 3'd2,
      ST_EXT   = 3'd3,
      ST_SLEEP = 3'd4
   } tss_state_e;

   localparam int MODE_W = 3;

   // codes 0..2 are crystal modes that need a settling count
   function automatic logic is_crystal(input logic [MODE_W-1:0] mode);
      return (mode <= MODE_W'(2));
   endfunction

   function automatic tss_state_e entry_state(input logic sel,
                                              input logic [MODE_W-1:0] mode);
      if (sel)                   return ST_INT;
      else if (is_crystal(mode)) return ST_COUNT;
      else                       return ST_EXT;
   endfunction

endpackage

// File: rtl/tss_sync.sv
module tss_sync #(
   parameter int STAGES   = 2,
   parameter bit NEG_EDGE = 1'b0
) (
   input  logic clk,
   input  logic clr_n,
   input  logic d,
   output logic q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("tss_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain;

   if (NEG_EDGE) begin : g_neg
      always_ff @(negedge clk or negedge clr_n) begin
         if (!clr_n) chain <= '0;
         else        chain <= (chain << 1) | STAGES'(d);
      end
   end else begin : g_pos
      always_ff @(posedge clk or negedge clr_n) begin
         if (!clr_n) chain <= '0;
         else        chain <= (chain << 1) | STAGES'(d);
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/tss_ost_counter.sv
module tss_ost_counter #(
   parameter int CNT_W = 11
) (
   input  logic ext_clk,
   input  logic clr_n,
   output logic done
);

   if (CNT_W < 2) begin : g_bad_width
      $error("tss_ost_counter: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] TERM = CNT_W'(1) << (CNT_W - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge ext_clk or negedge clr_n) begin
      if (!clr_n)               cnt <= '0;
      else if (!cnt[CNT_W-1])   cnt <= cnt + CNT_W'(1);
   end

   assign done = cnt[CNT_W-1];

   AST_CNT_BOUNDED: assert property (@(posedge ext_clk) disable iff (!clr_n)
      cnt <= TERM); // R3

endmodule

// File: rtl/tss_clk_handover.sv
module tss_clk_handover #(
   parameter int GUARD_STAGES = 0
) (
   input  logic int_clk,
   input  logic ext_clk,
   input  logic rst_n,
   input  logic want_int,
   input  logic want_ext,
   output logic int_en,
   output logic sys_clk
);

   if (GUARD_STAGES < 0) begin : g_bad_guard
      $error("tss_clk_handover: GUARD_STAGES must not be negative");
   end

   logic ext_en;
   logic ext_seen_by_int;
   logic int_seen_by_ext;

   if (GUARD_STAGES == 0) begin : g_direct
      assign ext_seen_by_int = ext_en;
      assign int_seen_by_ext = int_en;
   end else begin : g_guarded
      tss_sync #(.STAGES(GUARD_STAGES), .NEG_EDGE(1'b1)) u_to_int (
         .clk(int_clk), .clr_n(rst_n), .d(ext_en), .q(ext_seen_by_int));
      tss_sync #(.STAGES(GUARD_STAGES), .NEG_EDGE(1'b1)) u_to_ext (
         .clk(ext_clk), .clr_n(rst_n), .d(int_en), .q(int_seen_by_ext));
   end

   // each enable only changes while its own clock is low
   always_ff @(negedge int_clk or negedge rst_n) begin
      if (!rst_n) int_en <= 1'b0;
      else        int_en <= want_int & ~ext_seen_by_int;
   end

   always_ff @(negedge ext_clk or negedge rst_n) begin
      if (!rst_n) ext_en <= 1'b0;
      else        ext_en <= want_ext & ~int_seen_by_ext;
   end

   assign sys_clk = (int_clk & int_en) | (ext_clk & ext_en);

   AST_NO_OVERLAP: assert property (@(posedge int_clk) disable iff (!rst_n)
      !(int_en && ext_en)); // R5

   AST_EXT_AFTER_INT_OFF: assert property (@(negedge ext_clk) disable iff (!rst_n)
      $rose(ext_en) |-> !int_en); // R4

endmodule

// File: rtl/tss_clock_switcher.sv
module tss_clock_switcher
   import tss_pkg::*;
#(
   parameter int CNT_W        = 11,
   parameter int SYNC_STAGES  = 2,
   parameter int GUARD_STAGES = 0
) (
   input  logic              int_clk,
   input  logic              ext_clk,
   input  logic              rst_n,
   input  logic              por_release,
   input  logic              wake,
   input  logic              sleep_req,
   input  logic              clk_sel,
   input  logic [MODE_W-1:0] osc_mode,
   input  logic              sw_en,
   output logic              sys_clk,
   output logic              ext_active
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tss_clock_switcher: SYNC_STAGES must be at least 2");
   end

   tss_state_e state, state_n;
   logic       want_int_q, want_ext_q, cnt_run_q;
   logic       cnt_done, done_sync;
   logic       int_en;
   logic       status_q;

   always_comb begin
      state_n = state;
      unique case (state)
         ST_HOLD:  if (por_release) state_n = entry_state(clk_sel, osc_mode);
         ST_COUNT: if (sleep_req)   state_n = ST_SLEEP;
                   else if (done_sync) state_n = ST_EXT;
         ST_INT,
         ST_EXT:   if (sleep_req)   state_n = ST_SLEEP;
         ST_SLEEP: if (wake)        state_n = entry_state(clk_sel, osc_mode);
         default:  state_n = ST_HOLD;
      endcase
   end

   always_ff @(posedge int_clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_HOLD;
         want_int_q <= 1'b0;
         want_ext_q <= 1'b0;
         cnt_run_q  <= 1'b0;
      end else begin
         state      <= state_n;
         want_int_q <= (state_n == ST_INT) || ((state_n == ST_COUNT) && sw_en);
         want_ext_q <= (state_n == ST_EXT);
         cnt_run_q  <= (state_n == ST_COUNT);
      end
   end

   // counter and its synchroniser are cleared whenever no count is running
   tss_ost_counter #(.CNT_W(CNT_W)) u_ost (
      .ext_clk(ext_clk), .clr_n(cnt_run_q), .done(cnt_done));

   tss_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b0)) u_done_sync (
      .clk(int_clk), .clr_n(cnt_run_q), .d(cnt_done), .q(done_sync));

   tss_clk_handover #(.GUARD_STAGES(GUARD_STAGES)) u_mux (
      .int_clk(int_clk), .ext_clk(ext_clk), .rst_n(rst_n),
      .want_int(want_int_q), .want_ext(want_ext_q),
      .int_en(int_en), .sys_clk(sys_clk));

   // flag moves on the same internal falling edge that releases the internal side
   always_ff @(negedge int_clk or negedge rst_n) begin
      if (!rst_n) status_q <= 1'b0;
      else        status_q <= want_ext_q;
   end

   assign ext_active = status_q;

   AST_SLEEP_ABORTS: assert property (@(posedge int_clk) disable iff (!rst_n)
      (state == ST_COUNT && sleep_req) |=> (state == ST_SLEEP && !cnt_run_q)); // R8

   AST_SLEEP_FLAG_LOW: assert property (@(posedge int_clk) disable iff (!rst_n)
      (state == ST_SLEEP && $past(state) == ST_SLEEP) |-> !status_q); // R8

   AST_INT_FLAG_LOW: assert property (@(posedge int_clk) disable iff (!rst_n)
      (state == ST_INT && $past(state) == ST_INT) |-> (!status_q && int_en)); // R6

   AST_FLAG_ONLY_EXT: assert property (@(posedge int_clk) disable iff (!rst_n)
      $rose(status_q) |-> (state == ST_EXT && !int_en)); // R3

endmodule

// File: tb/tb_tss_clock_switcher.sv
`timescale 1ns/1ps
module tb_tss_clock_switcher;

   logic       int_clk = 1'b0;
   logic       ext_clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       por_release = 1'b0, wake = 1'b0, sleep_req = 1'b0;
   logic       clk_sel = 1'b0, sw_en = 1'b1;
   logic [2:0] osc_mode = 3'd1;
   logic       sys_clk, ext_active;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   typedef struct {
      bit    val;
      int    min_e;
      int    max_e;
      string tag;
   } exp_t;
   exp_t exp_q[$];

   int ext_edges = 0;
   int base = 0;

   always #2.5 int_clk = ~int_clk;          // 200 MHz
   initial begin
      #0.13;
      forever #3.35 ext_clk = ~ext_clk;     // unrelated period, edges never coincide
   end
   always @(posedge ext_clk) ext_edges++;

   tss_clock_switcher dut (
      .int_clk(int_clk), .ext_clk(ext_clk), .rst_n(rst_n),
      .por_release(por_release), .wake(wake), .sleep_req(sleep_req),
      .clk_sel(clk_sel), .osc_mode(osc_mode), .sw_en(sw_en),
      .sys_clk(sys_clk), .ext_active(ext_active));

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   // pulse-width monitor
   realtime last_t = 0.0;
   bit      pw_on = 0;
   int      pw_bad = 0;
   always @(sys_clk) begin
      if (pw_on && ($realtime - last_t) < 2.4) pw_bad++;
      last_t = $realtime;
   end

   // scoreboard monitor: every flag change must match the next queued item
   initial begin
      wait (rst_n === 1'b1);
      forever begin
         @(ext_active);
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8", "unexpected flag change", int'(ext_active), 0);
         end else begin
            automatic exp_t e = exp_q.pop_front();
            automatic int n = ext_edges - base;
            chk(ext_active == e.val, e.tag, "flag value", int'(ext_active), int'(e.val));
            chk(n >= e.min_e && n <= e.max_e, e.tag, "external edges at flag change",
                n, e.min_e);
            if (e.val) begin
               #0.1;
               chk(int_clk == 1'b0, "R4", "int_clk at flag rise", int'(int_clk), 0);
               chk(sys_clk == 1'b0, "R4", "sys_clk at flag rise", int'(sys_clk), 0);
               @(posedge sys_clk);
               chk(ext_clk == 1'b1, "R4", "first high phase comes from ext_clk",
                   int'(ext_clk), 1);
            end
         end
      end
   end

   task automatic pulse_in(input int which);
      @(negedge int_clk);
      case (which)
         0: por_release = 1'b1;
         1: wake = 1'b1;
         default: sleep_req = 1'b1;
      endcase
      @(posedge int_clk);
      base = ext_edges;
      @(negedge int_clk);
      por_release = 1'b0; wake = 1'b0; sleep_req = 1'b0;
   endtask

   task automatic ext_wait(input int n);
      repeat (n) @(posedge ext_clk);
   endtask

   // kind 0: follows int_clk, 1: follows ext_clk, 2: held low
   task automatic expect_src(input int kind, input string tag);
      repeat (4) begin
         if (kind == 1) begin
            @(posedge ext_clk); #0.4;
            chk(sys_clk == 1'b1, tag, "sys_clk high with ext_clk", int'(sys_clk), 1);
            @(negedge ext_clk); #0.4;
            chk(sys_clk == 1'b0, tag, "sys_clk low with ext_clk", int'(sys_clk), 0);
         end else if (kind == 0) begin
            @(posedge int_clk); #0.4;
            chk(sys_clk == 1'b1, tag, "sys_clk high with int_clk", int'(sys_clk), 1);
            @(negedge int_clk); #0.4;
            chk(sys_clk == 1'b0, tag, "sys_clk low with int_clk", int'(sys_clk), 0);
         end else begin
            @(posedge int_clk); #0.4;
            chk(sys_clk == 1'b0, tag, "sys_clk held low (int high)", int'(sys_clk), 0);
            @(posedge ext_clk); #0.4;
            chk(sys_clk == 1'b0, tag, "sys_clk held low (ext high)", int'(sys_clk), 0);
         end
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #400us;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (4) @(posedge int_clk);
      @(negedge int_clk);
      rst_n = 1'b1;
      pw_on = 1;
      // R1: nothing before the release pulse
      expect_src(2, "R1");
      chk(ext_active == 1'b0, "R1", "flag after reset", int'(ext_active), 0);

      // R2 / R3 / R4: standard crystal, two-speed
      exp_q.push_back('{1'b1, 1024, 1030, "R3"});
      pulse_in(0);
      expect_src(0, "R2");
      chk(ext_active == 1'b0, "R2", "flag during count", int'(ext_active), 0);
      ext_wait(1100);
      chk(ext_active == 1'b1, "R3", "flag after count", int'(ext_active), 1);
      expect_src(1, "R4");

      // R8: sleep from external run
      exp_q.push_back('{1'b0, 0, 5, "R8"});
      pulse_in(2);
      ext_wait(10);
      expect_src(2, "R8");
      chk(ext_active == 1'b0, "R8", "flag in sleep", int'(ext_active), 0);

      // R9: wake restarts a full count (high-speed crystal)
      osc_mode = 3'd2;
      exp_q.push_back('{1'b1, 1024, 1030, "R9"});
      pulse_in(1);
      ext_wait(500);
      expect_src(0, "R9");
      chk(ext_active == 1'b0, "R9", "flag mid count after wake", int'(ext_active), 0);
      ext_wait(700);
      chk(ext_active == 1'b1, "R9", "flag after second count", int'(ext_active), 1);
      expect_src(1, "R9");

      // R8: sleep in the middle of a count (low-power crystal)
      exp_q.push_back('{1'b0, 0, 5, "R8"});
      pulse_in(2);
      ext_wait(10);
      osc_mode = 3'd0;
      pulse_in(1);
      ext_wait(300);
      expect_src(0, "R2");
      pulse_in(2);
      ext_wait(1500);
      chk(ext_active == 1'b0, "R8", "flag after aborted count", int'(ext_active), 0);
      expect_src(2, "R8");

      // R6: software select forces internal clock
      clk_sel = 1'b1;
      pulse_in(1);
      ext_wait(1500);
      expect_src(0, "R6");
      chk(ext_active == 1'b0, "R6", "flag with internal select", int'(ext_active), 0);
      pulse_in(2);
      ext_wait(10);

      // R7: non-crystal mode switches at once
      clk_sel = 1'b0;
      osc_mode = 3'd3;
      exp_q.push_back('{1'b1, 0, 6, "R7"});
      pulse_in(1);
      ext_wait(10);
      chk(ext_active == 1'b1, "R7", "flag without count", int'(ext_active), 1);
      expect_src(1, "R7");

      // R10: switchover disabled, clock held low during count
      exp_q.push_back('{1'b0, 0, 5, "R8"});
      pulse_in(2);
      ext_wait(10);
      osc_mode = 3'd1;
      sw_en = 1'b0;
      exp_q.push_back('{1'b1, 1024, 1030, "R10"});
      pulse_in(1);
      ext_wait(500);
      expect_src(2, "R10");
      chk(ext_active == 1'b0, "R10", "flag during held count", int'(ext_active), 0);
      ext_wait(700);
      chk(ext_active == 1'b1, "R10", "flag after held count", int'(ext_active), 1);
      expect_src(1, "R10");

      ext_wait(5);
      chk(pw_bad == 0, "R5", "short pulses on sys_clk", pw_bad, 0);
      chk(exp_q.size() == 0, "R3", "flag changes still outstanding", exp_q.size(), 0);
      finish_run();
   end

endmodule